// File: doc/BRIEF.md
# Watchdog Timer with Shared Rate Divider

This block supervises a processor with a watchdog counter that advances on its own free-running tick. That tick stays live while the main clock is halted for low-power sleep. A single binary divider is shared between two users, and a routing bit decides which one owns it. When the watchdog owns the divider, it stretches the watchdog period as a postscaler behind the base counter. When the general-purpose timer owns it, it divides the timer's count source before that source reaches the timer counter. A 3-bit rate field selects one of eight divide taps in either case.

A watchdog expiry while the core is running raises a one-cycle device reset request. An expiry while the core sleeps raises a one-cycle wake request instead. Every expiry pulls an active-low expiry flag to 0. Software holds the watchdog off by issuing clear strobes, and a sleep entry strobe also restarts it. Both strobes zero the base counter, but they zero the divider only while the watchdog owns it. A configuration enable bit tied to 0 turns the watchdog off for good.

Top module: `wdog_shared_prescale`

## Requirements
- R1: After power-on reset, resetReq and wakeReq are 0, expiryN is 1 and timerTick is 0.
- R2: With divOwner=1 (divider owned by the watchdog), wdtEnable=1 and awake=0, resetReq rises exactly 2^BASE_W * 2^divRate base ticks after a restart. It is one cycle wide. Cycles without a base tick do not advance the count.
- R3: With divOwner=0, expiry comes straight from the base counter after exactly 2^BASE_W base ticks, whatever divRate holds.
- R4: When asleep=1 at expiry, wakeReq pulses for one cycle and resetReq stays 0. resetReq and wakeReq are never high together.
- R5: Every expiry drives expiryN to 0. A clear strobe returns it to 1.
- R6: With wdtEnable=0, no reset or wake request is ever produced. The base count is held at zero, so after re-enabling, expiry again needs the full period.
- R7: A clear strobe or a sleep strobe restarts the full watchdog period. A base tick in the same cycle as the strobe is discarded.
- R8: A clear strobe while divOwner=0 leaves the divider count untouched, so the timer's divided tick keeps its phase.
- R9: With divOwner=0, timerTick pulses once per 2^divRate timer source pulses, one cycle after the completing pulse. The divider is taken as starting from zero.
- R10: With divOwner=1, timerTick follows timerSrc one cycle later, undivided.
- R11: Outputs are registered. Each request appears in the cycle after the clock edge that samples the completing tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-on reset |
| wdtTick | input | 1 | Free-running watchdog base tick (enable) |
| timerSrc | input | 1 | Timer count source pulse (enable) |
| clrStrobe | input | 1 | Watchdog clear strobe |
| sleepStrobe | input | 1 | Sleep entry strobe |
| asleep | input | 1 | Core is in sleep mode |
| wdtEnable | input | 1 | Watchdog enable configuration bit |
| divOwner | input | 1 | 1: divider behind watchdog, 0: divider in front of timer |
| divRate | input | 3 | Divider tap select, ratio 2^divRate |
| resetReq | output | 1 | One-cycle device reset request |
| wakeReq | output | 1 | One-cycle wake-up request |
| expiryN | output | 1 | Active-low expiry flag |
| timerTick | output | 1 | Tick to the timer counter |

## Verification
A wrong base count or divider count shows up as a request that comes a different number of cycles after a restart than the arithmetic product of base size and tap ratio predicts. With a tick every cycle, this is visible within one full period. A divider zeroed when it should not be, or left running when it should be cleared, moves the phase of the next timerTick. That shift appears within 2^divRate source pulses. A wrong sleep or ownership decode produces the wrong request line, or a wrong ratio at the very first expiry.

// File: rtl/wdp_pkg.sv
package wdp_pkg;
  // Strobes sent by the control to the datapath
  typedef struct packed {
    logic clrBase;  // zero the base watchdog counter
    logic clrDiv;   // zero the shared divider
    logic runBase;  // base counter allowed to advance
    logic toWdt;    // divider routed behind the watchdog
  } wdpStrobe_t;
endpackage

// File: rtl/wdp_ctrl.sv
module wdp_ctrl
  import wdp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clrStrobe,
  input  logic       sleepStrobe,
  input  logic       asleep,
  input  logic       wdtEnable,
  input  logic       divOwner,
  input  logic       expiryEv,
  output wdpStrobe_t strb,
  output logic       resetReq,
  output logic       wakeReq,
  output logic       expiryN
);
  logic restart;

  always_comb begin
    restart      = clrStrobe | sleepStrobe;
    strb.clrBase = restart;
    strb.clrDiv  = restart & divOwner;
    strb.runBase = wdtEnable;
    strb.toWdt   = divOwner;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetReq <= 1'b0;
      wakeReq  <= 1'b0;
      expiryN  <= 1'b1;
    end else begin
      resetReq <= expiryEv & ~asleep;
      wakeReq  <= expiryEv & asleep;
      if (clrStrobe)     expiryN <= 1'b1;
      else if (expiryEv) expiryN <= 1'b0;
    end
  end

  p_req_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(resetReq && wakeReq));
  p_reset_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);
  p_wake_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |=> !wakeReq);
  p_flag_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (resetReq || wakeReq) |-> !expiryN);
  p_clear_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    clrStrobe |=> expiryN);
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !wdtEnable |=> (!resetReq && !wakeReq));
endmodule

// File: rtl/wdp_datapath.sv
module wdp_datapath
  import wdp_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter int DIV_W  = 8,
  parameter int RATE_W = $clog2(DIV_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdpStrobe_t        strb,
  input  logic              wdtTick,
  input  logic              timerSrc,
  input  logic [RATE_W-1:0] divRate,
  output logic              expiryEv,
  output logic              timerTick
);
  logic [BASE_W-1:0] baseCnt;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  tapVec;
  logic              baseOvf;
  logic              divIn;
  logic              tapSel;

  // base watchdog counter, held at zero while disabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            baseCnt <= '0;
    else if (strb.clrBase || !strb.runBase) baseCnt <= '0;
    else if (wdtTick)                     baseCnt <= baseCnt + 1'b1;
  end

  always_comb begin
    baseOvf = strb.runBase & wdtTick & ~strb.clrBase & (&baseCnt);
    divIn   = strb.toWdt ? baseOvf : timerSrc;
  end

  // shared divider count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            divCnt <= '0;
    else if (strb.clrDiv) divCnt <= '0;
    else if (divIn)       divCnt <= divCnt + 1'b1;
  end

  // tap n fires on every 2^n-th divider input
  for (genvar n = 0; n < DIV_W; n++) begin : g_tap
    localparam logic [DIV_W-1:0] TapMask = (DIV_W'(1) << n) - DIV_W'(1);
    assign tapVec[n] = divIn && ((divCnt & TapMask) == TapMask);
  end

  always_comb begin
    tapSel   = tapVec[divRate];
    expiryEv = strb.toWdt ? tapSel : baseOvf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timerTick <= 1'b0;
    else       timerTick <= strb.toWdt ? timerSrc : tapSel;
  end

  p_clr_base_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrBase |=> (baseCnt == '0));
  p_div_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrBase && !strb.clrDiv && !divIn) |=> $stable(divCnt));
  p_pass_through_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.toWdt |=> (timerTick == $past(timerSrc)));
  p_no_expiry_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.runBase |-> !expiryEv);
endmodule

// File: rtl/wdog_shared_prescale.sv
module wdog_shared_prescale
  import wdp_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wdtTick,
  input  logic       timerSrc,
  input  logic       clrStrobe,
  input  logic       sleepStrobe,
  input  logic       asleep,
  input  logic       wdtEnable,
  input  logic       divOwner,
  input  logic [2:0] divRate,
  output logic       resetReq,
  output logic       wakeReq,
  output logic       expiryN,
  output logic       timerTick
);
  localparam int RateW = $clog2(DIV_W);

  wdpStrobe_t strb;
  logic       expiryEv;

  wdp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clrStrobe(clrStrobe), .sleepStrobe(sleepStrobe),
    .asleep(asleep), .wdtEnable(wdtEnable), .divOwner(divOwner),
    .expiryEv(expiryEv), .strb(strb), .resetReq(resetReq),
    .wakeReq(wakeReq), .expiryN(expiryN)
  );

  wdp_datapath #(.BASE_W(BASE_W), .DIV_W(DIV_W), .RATE_W(RateW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdtTick(wdtTick),
    .timerSrc(timerSrc), .divRate(divRate[RateW-1:0]),
    .expiryEv(expiryEv), .timerTick(timerTick)
  );
endmodule

// File: tb/sim_wdog_shared_prescale.sv
module sim_wdog_shared_prescale;
  localparam int BW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wdtTick = 1'b0, timerSrc = 1'b0, clrStrobe = 1'b0, sleepStrobe = 1'b0;
  logic asleep = 1'b0, wdtEnable = 1'b1, divOwner = 1'b1;
  logic [2:0] divRate = 3'd0;
  logic resetReq, wakeReq, expiryN, timerTick;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  wdog_shared_prescale #(.BASE_W(BW), .DIV_W(8)) u0 (
    .clk(clk), .rstN(rstN), .wdtTick(wdtTick), .timerSrc(timerSrc),
    .clrStrobe(clrStrobe), .sleepStrobe(sleepStrobe), .asleep(asleep),
    .wdtEnable(wdtEnable), .divOwner(divOwner), .divRate(divRate),
    .resetReq(resetReq), .wakeReq(wakeReq), .expiryN(expiryN),
    .timerTick(timerTick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(input bit useSleep);
    @(negedge clk);
    if (useSleep) sleepStrobe = 1'b1; else clrStrobe = 1'b1;
    @(negedge clk);
    sleepStrobe = 1'b0;
    clrStrobe   = 1'b0;
  endtask

  // counts cycles until the chosen request; flags the other one
  task automatic measure(input bit wantWake, input int limit, output int n, output bit other);
    n = 0;
    other = 1'b0;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (wantWake ? resetReq : wakeReq) other = 1'b1;
      if (wantWake ? wakeReq : resetReq) begin
        n = k;
        break;
      end
    end
  endtask

  task automatic zeroDivider();
    wdtTick  = 1'b0;
    divOwner = 1'b1;
    restart(1'b0);
  endtask

  task automatic timerCount(input int limit, output int n);
    n = 0;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (timerTick) begin
        n = k;
        break;
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int n;
    bit other;
    int expN;
    bit [7:0] pat;

    repeat (3) @(negedge clk);
    chk(resetReq == 0 && wakeReq == 0, "R1 requests", resetReq + wakeReq, 0);
    chk(expiryN == 1, "R1 expiryN", expiryN, 1);
    chk(timerTick == 0, "R1 timerTick", timerTick, 0);
    rstN = 1'b1;

    // R2, R5, R7, R11: divider behind watchdog, every rate
    for (int r = 0; r < 8; r++) begin
      divOwner = 1'b1; divRate = 3'(r); asleep = 1'b0; wdtTick = 1'b1;
      restart(1'b0);  // tick in the strobe cycle is discarded (R7)
      chk(expiryN == 1, "R5 flag after clear", expiryN, 1);
      expN = (1 << BW) * (1 << r);
      measure(1'b0, expN + 4, n, other);
      chk(n == expN, "R2 period with postscale", n, expN);
      chk(!other, "R4 no wake while awake", other, 0);
      chk(expiryN == 0, "R5 flag after expiry", expiryN, 0);
      @(negedge clk);
      chk(resetReq == 0, "R2 pulse width", resetReq, 0);
    end

    // R2: no ticks, no progress
    wdtTick = 1'b0; divRate = 3'd0;
    restart(1'b0);
    measure(1'b0, 60, n, other);
    chk(n == 0, "R2 idle without ticks", n, 0);

    // R3: divider on timer side, expiry from base counter only
    for (int r = 0; r < 8; r++) begin
      divOwner = 1'b0; divRate = 3'(r); wdtTick = 1'b1;
      restart(1'b0);
      measure(1'b0, 40, n, other);
      chk(n == (1 << BW), "R3 base period", n, 1 << BW);
    end

    // R4: asleep, sleep strobe restarts, wake instead of reset
    for (int r = 0; r < 3; r++) begin
      divOwner = 1'b1; divRate = 3'(r); asleep = 1'b1; wdtTick = 1'b1;
      restart(1'b1);
      expN = (1 << BW) * (1 << r);
      measure(1'b1, expN + 4, n, other);
      chk(n == expN, "R4 wake period", n, expN);
      chk(!other, "R4 no reset while asleep", other, 0);
      @(negedge clk);
      chk(wakeReq == 0, "R4 wake pulse width", wakeReq, 0);
    end
    asleep = 1'b0;

    // R7: mid-run clear restarts the full period
    divOwner = 1'b0; wdtTick = 1'b1;
    restart(1'b0);
    repeat (10) @(negedge clk);
    restart(1'b0);
    measure(1'b0, 40, n, other);
    chk(n == (1 << BW), "R7 restart mid-run", n, 1 << BW);

    // R6: disabled watchdog stays silent, restarts from zero
    restart(1'b0);
    wdtEnable = 1'b0;
    measure(1'b0, 80, n, other);
    chk(n == 0 && !other, "R6 disabled silent", n, 0);
    chk(expiryN == 1, "R6 flag untouched", expiryN, 1);
    wdtEnable = 1'b1;
    measure(1'b0, 40, n, other);
    chk(n == (1 << BW), "R6 full period after enable", n, 1 << BW);

    // R9: timer-side division at every rate
    for (int r = 0; r < 8; r++) begin
      zeroDivider();
      divOwner = 1'b0; divRate = 3'(r); timerSrc = 1'b1;
      timerCount(300, n);
      chk(n == (1 << r), "R9 first divided tick", n, 1 << r);
      timerCount(300, n);
      chk(n == (1 << r), "R9 divided interval", n, 1 << r);
      timerSrc = 1'b0;
    end

    // R8: clear in timer ownership keeps divider phase
    zeroDivider();
    divOwner = 1'b0; divRate = 3'd2;
    @(negedge clk); timerSrc = 1'b1;
    @(negedge clk);
    @(negedge clk); timerSrc = 1'b0;
    chk(timerTick == 0, "R8 no tick yet", timerTick, 0);
    restart(1'b0);
    timerSrc = 1'b1;
    timerCount(20, n);
    chk(n == 2, "R8 phase kept over clear", n, 2);
    timerSrc = 1'b0;

    // R10: pass-through when watchdog owns the divider
    divOwner = 1'b1; divRate = 3'd5; wdtTick = 1'b0;
    pat = 8'b1011_0010;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(timerTick == ((i == 0) ? 1'b0 : pat[i-1]), "R10 pass-through",
          timerTick, (i == 0) ? 0 : int'(pat[i-1]));
      timerSrc = pat[i];
    end
    @(negedge clk);
    chk(timerTick == pat[7], "R10 pass-through last", timerTick, pat[7]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule